// File: doc/BRIEF.md
# Configuration Load Sequencer

This block takes a device from reset release to a loaded configuration. On the first cycle after reset it captures a fuse word. It then clears every configuration frame by writing zeros to each one in turn, unless a bypass input skips that step. Once the clear is done it raises a ready status and starts accepting 32-bit bitstream words on a valid/ready stream.

Words are discarded until the sync pattern arrives. The next word must equal the device identifier. After that, command words steer the data words that follow either to a small IO-ring register space or into the core frame memory. Core words are packed into full frames, and each full frame is written with a single strobe. A finish command closes the load. It is followed by a check word that is compared against a running CRC. A passing load sets a done flag. An identifier mismatch or a CRC mismatch sets a sticky error flag. In every case the sequencer then goes back to hunting for sync.

Back-pressure: `s_ready` is low from reset until the ready status is released, and high after that. A word is taken only on a cycle where `s_valid` and `s_ready` are both high. The producer must hold `s_data` steady while `s_valid` is high and `s_ready` is low.

Top module: `cfgl_top`

## Requirements
- R1: On the first clock after reset release, `fuse_q` captures `fuse_word`. It then holds that value until the next reset, whatever `fuse_word` does.
- R2: With `clr_bypass` low, the block issues FRAMES frame writes before the status is released. Each write carries all-zero data, and the addresses run 0, 1, … FRAMES-1 in ascending order.
- R3: `cfg_status` is low during reset and during the clear phase. It goes high once the clear is finished, or right after the fuse capture when `clr_bypass` is high. In the bypass case no clear writes are issued. Once high, `cfg_status` stays high until reset.
- R4: `s_ready` is low whenever `cfg_status` is low. A word transfers only on a cycle where `s_valid` and `s_ready` are both high.
- R5: Every word before one equal to 0xAA55AA55 is discarded and has no effect. That word achieves sync.
- R6: The word after sync must equal `dev_id`. If it does not, `err_flag` is set, and no IO or frame writes follow until a new sync is found.
- R7: A command word carries its opcode in bits [31:24] and its count in bits [15:0]. The opcodes are 0x00 for no-op, 0x01 for an IO write, 0x02 for a core write and 0x0C for finish. Any other opcode is ignored like a no-op. A count of zero takes no data words.
- R8: An IO write of count N consumes the next N words. For each one it pulses `io_we` once, with `io_addr` running from 0 and `io_data` carrying the word.
- R9: A core write of count N consumes the next N words. Every FRAME_WORDS consecutive words produce one frame write. The first word of a frame occupies the least significant 32 bits. Frame addresses start at 0 for each core command. Words left over that do not fill a frame are dropped.
- R10: The CRC is CRC-32 with polynomial 0x04C11DB7 and initial value 0xFFFFFFFF. Bits are taken MSB first, with no reflection and no final XOR. It runs over every word after the identifier, up to and including the finish command. The word after finish is the check word. If it matches, `load_done` is set and stays set.
- R11: With `crc_en` high, a check word that does not match sets `err_flag` and leaves `load_done` low. With `crc_en` low, any check word is accepted. `err_flag` is sticky.
- R12: After a finish or an identifier mismatch, the block hunts for sync again, and a following complete bitstream loads normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fuse_word | input | 32 | Fuse contents to be captured |
| clr_bypass | input | 1 | Skip the frame clear phase |
| crc_en | input | 1 | Enforce the CRC check |
| dev_id | input | 32 | Expected device identifier |
| s_valid | input | 1 | Bitstream word valid |
| s_data | input | 32 | Bitstream word |
| s_ready | output | 1 | Sequencer accepts a word |
| fuse_q | output | 32 | Captured fuse word |
| cfg_status | output | 1 | Ready status, high once the clear is done |
| frm_we | output | 1 | Frame write strobe |
| frm_addr | output | $clog2(FRAMES) | Frame address |
| frm_data | output | 32*FRAME_WORDS | Frame data |
| io_we | output | 1 | IO register write strobe |
| io_addr | output | IO_AW | IO register index |
| io_data | output | 32 | IO register data |
| load_done | output | 1 | Load finished with a good check |
| err_flag | output | 1 | Sticky identifier or CRC error |

## Verification
Two resets, one with the clear phase and one with it bypassed, show whether the block really writes zero frames and releases the status at the right point. A clean stream is led by junk words and contains no-ops, an unknown opcode, a zero-count command, IO data and a core run with a partial frame. It checks discarding, packing order, address restart and the dropping of leftover words. Streams with a wrong identifier and with a wrong check word, under both settings of `crc_en`, separate the error paths from the pass path. Each is followed by a clean reload to show that the block recovers.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
  localparam int WORD_W = 32;
  localparam logic [31:0] SYNC_WORD = 32'hAA55AA55;
  localparam logic [31:0] CRC_POLY  = 32'h04C11DB7;
  localparam logic [31:0] CRC_SEED  = 32'hFFFFFFFF;

  localparam logic [7:0] OP_NOP  = 8'h00;
  localparam logic [7:0] OP_IO   = 8'h01;
  localparam logic [7:0] OP_CORE = 8'h02;
  localparam logic [7:0] OP_FIN  = 8'h0C;

  typedef enum logic [2:0] {
    ST_FUSE, ST_CLEAR, ST_HUNT, ST_ID, ST_CMD, ST_IO, ST_CORE, ST_CHK
  } seq_state_t;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [31:0] w);
    logic [31:0] r;
    logic fb;
    r = c;
    for (int i = 31; i >= 0; i--) begin
      fb = r[31] ^ w[i];
      r  = {r[30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
    end
    return r;
  endfunction
endpackage

// File: rtl/cfgl_crc.sv
module cfgl_crc
  import cfgl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        upd,
  input  logic [31:0] word,
  output logic [31:0] crc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc <= CRC_SEED;
    else if (init) crc <= CRC_SEED;
    else if (upd)  crc <= crc_step(crc, word);
  end

  // R10: the running value moves only when a word is folded in or restarted
  a_r10_crc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && !upd) |=> $stable(crc));
endmodule

// File: rtl/cfgl_frame_asm.sv
module cfgl_frame_asm
  import cfgl_pkg::*;
#(
  parameter int FRAMES      = 8,
  parameter int FRAME_WORDS = 2,
  localparam int FA_W    = (FRAMES > 1) ? $clog2(FRAMES) : 1,
  localparam int FRAME_W = WORD_W * FRAME_WORDS,
  localparam int FI_W    = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_we,
  input  logic [FA_W-1:0]    clr_addr,
  input  logic               start,
  input  logic               push,
  input  logic [WORD_W-1:0]  word,
  output logic               frm_we,
  output logic [FA_W-1:0]    frm_addr,
  output logic [FRAME_W-1:0] frm_data
);
  logic [FRAME_W-1:0] acc;
  logic [FRAME_W-1:0] packed_w;
  logic [FI_W-1:0]    fill;
  logic [FA_W-1:0]    next_addr;
  logic               last_word;

  generate
    if (FRAME_WORDS == 1) begin : g_single
      assign packed_w = word;
    end else begin : g_multi
      assign packed_w = {word, acc[FRAME_W-1:WORD_W]};
    end
  endgenerate

  assign last_word = (fill == FI_W'(FRAME_WORDS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0; fill <= '0; next_addr <= '0;
      frm_we <= 1'b0; frm_addr <= '0; frm_data <= '0;
    end else begin
      frm_we <= 1'b0;
      if (clr_we) begin
        frm_we   <= 1'b1;
        frm_addr <= clr_addr;
        frm_data <= '0;
      end else if (start) begin
        fill      <= '0;
        next_addr <= '0;
      end else if (push) begin
        acc <= packed_w;
        if (last_word) begin
          frm_we    <= 1'b1;
          frm_addr  <= next_addr;
          frm_data  <= packed_w;
          next_addr <= next_addr + 1'b1;
          fill      <= '0;
        end else begin
          fill <= fill + 1'b1;
        end
      end
    end
  end

  // R9: a frame strobe always traces back to a clear step or a pushed word
  a_r9_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
    frm_we |-> ($past(clr_we) || $past(push)));
  // R9: the packing position never passes the frame size
  a_r9_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    32'(fill) < FRAME_WORDS);
endmodule

// File: rtl/cfgl_fsm.sv
module cfgl_fsm
  import cfgl_pkg::*;
#(
  parameter int FRAMES = 8,
  parameter int IO_AW  = 6,
  localparam int FA_W  = (FRAMES > 1) ? $clog2(FRAMES) : 1
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      fuse_word,
  input  logic             clr_bypass,
  input  logic             crc_en,
  input  logic [31:0]      dev_id,
  input  logic             s_valid,
  input  logic [31:0]      s_data,
  output logic             s_ready,
  output logic [31:0]      fuse_q,
  output logic             cfg_status,
  output logic             io_we,
  output logic [IO_AW-1:0] io_addr,
  output logic [31:0]      io_data,
  output logic             load_done,
  output logic             err_flag,
  input  logic [31:0]      crc_val,
  output logic             crc_init,
  output logic             crc_upd,
  output logic             core_start,
  output logic             core_push,
  output logic             clr_we,
  output logic [FA_W-1:0]  clr_addr
);
  seq_state_t       state;
  logic [15:0]      remain;
  logic [IO_AW-1:0] io_idx;
  logic [FA_W-1:0]  clr_cnt;
  logic             fire;
  logic [7:0]       op;
  logic [15:0]      cnt;

  assign op  = s_data[31:24];
  assign cnt = s_data[15:0];

  always_comb begin
    s_ready = (state == ST_HUNT) || (state == ST_ID) || (state == ST_CMD) ||
              (state == ST_IO) || (state == ST_CORE) || (state == ST_CHK);
    fire       = s_valid && s_ready;
    crc_init   = fire && ((state == ST_HUNT) || (state == ST_ID));
    crc_upd    = fire && ((state == ST_CMD) || (state == ST_IO) || (state == ST_CORE));
    core_start = fire && (state == ST_CMD) && (op == OP_CORE);
    core_push  = fire && (state == ST_CORE);
    clr_we     = (state == ST_CLEAR);
    clr_addr   = clr_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_FUSE; remain <= '0; io_idx <= '0; clr_cnt <= '0;
      fuse_q <= '0; cfg_status <= 1'b0;
      io_we <= 1'b0; io_addr <= '0; io_data <= '0;
      load_done <= 1'b0; err_flag <= 1'b0;
    end else begin
      io_we <= 1'b0;
      unique case (state)
        ST_FUSE: begin
          fuse_q <= fuse_word;
          if (clr_bypass) begin
            state      <= ST_HUNT;
            cfg_status <= 1'b1;
          end else begin
            state   <= ST_CLEAR;
            clr_cnt <= '0;
          end
        end
        ST_CLEAR: begin
          if (32'(clr_cnt) == FRAMES - 1) begin
            state      <= ST_HUNT;
            cfg_status <= 1'b1;
          end else begin
            clr_cnt <= clr_cnt + 1'b1;
          end
        end
        ST_HUNT: if (fire && s_data == SYNC_WORD) state <= ST_ID;
        ST_ID: if (fire) begin
          if (s_data == dev_id) state <= ST_CMD;
          else begin
            err_flag <= 1'b1;
            state    <= ST_HUNT;
          end
        end
        ST_CMD: if (fire) begin
          remain <= cnt;
          io_idx <= '0;
          if (op == OP_IO && cnt != 16'd0)        state <= ST_IO;
          else if (op == OP_CORE && cnt != 16'd0) state <= ST_CORE;
          else if (op == OP_FIN)                  state <= ST_CHK;
        end
        ST_IO: if (fire) begin
          io_we   <= 1'b1;
          io_addr <= io_idx;
          io_data <= s_data;
          io_idx  <= io_idx + 1'b1;
          remain  <= remain - 16'd1;
          if (remain == 16'd1) state <= ST_CMD;
        end
        ST_CORE: if (fire) begin
          remain <= remain - 16'd1;
          if (remain == 16'd1) state <= ST_CMD;
        end
        ST_CHK: if (fire) begin
          if (!crc_en || s_data == crc_val) load_done <= 1'b1;
          else                              err_flag  <= 1'b1;
          state <= ST_HUNT;
        end
        default: state <= ST_HUNT;
      endcase
    end
  end

  // R3: once released the status stays released
  a_r3_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_status |=> cfg_status);
  // R4: no word is taken while the status is still held low
  a_r4_no_take_early: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_status |-> !s_ready);
  // R10: done is sticky
  a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> load_done);
  // R11: error is sticky
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);
  // R1: the captured fuse word never changes after the capture cycle
  a_r1_fuse_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_FUSE) |=> $stable(fuse_q));
endmodule

// File: rtl/cfgl_top.sv
module cfgl_top
  import cfgl_pkg::*;
#(
  parameter int FRAMES      = 8,
  parameter int FRAME_WORDS = 2,
  parameter int IO_AW       = 6,
  localparam int FA_W    = (FRAMES > 1) ? $clog2(FRAMES) : 1,
  localparam int FRAME_W = 32 * FRAME_WORDS
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [31:0]        fuse_word,
  input  logic               clr_bypass,
  input  logic               crc_en,
  input  logic [31:0]        dev_id,
  input  logic               s_valid,
  input  logic [31:0]        s_data,
  output logic               s_ready,
  output logic [31:0]        fuse_q,
  output logic               cfg_status,
  output logic               frm_we,
  output logic [FA_W-1:0]    frm_addr,
  output logic [FRAME_W-1:0] frm_data,
  output logic               io_we,
  output logic [IO_AW-1:0]   io_addr,
  output logic [31:0]        io_data,
  output logic               load_done,
  output logic               err_flag
);
  logic [31:0]     crc_val;
  logic            crc_init, crc_upd, core_start, core_push, clr_we;
  logic [FA_W-1:0] clr_addr;

  cfgl_fsm #(.FRAMES(FRAMES), .IO_AW(IO_AW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .fuse_word(fuse_word), .clr_bypass(clr_bypass),
    .crc_en(crc_en), .dev_id(dev_id), .s_valid(s_valid), .s_data(s_data),
    .s_ready(s_ready), .fuse_q(fuse_q), .cfg_status(cfg_status),
    .io_we(io_we), .io_addr(io_addr), .io_data(io_data),
    .load_done(load_done), .err_flag(err_flag), .crc_val(crc_val),
    .crc_init(crc_init), .crc_upd(crc_upd), .core_start(core_start),
    .core_push(core_push), .clr_we(clr_we), .clr_addr(clr_addr)
  );

  cfgl_crc u_crc (
    .clk(clk), .rst_n(rst_n), .init(crc_init), .upd(crc_upd),
    .word(s_data), .crc(crc_val)
  );

  cfgl_frame_asm #(.FRAMES(FRAMES), .FRAME_WORDS(FRAME_WORDS)) u_asm (
    .clk(clk), .rst_n(rst_n), .clr_we(clr_we), .clr_addr(clr_addr),
    .start(core_start), .push(core_push), .word(s_data),
    .frm_we(frm_we), .frm_addr(frm_addr), .frm_data(frm_data)
  );
endmodule

// File: tb/cfgl_top_bench.sv
module cfgl_top_bench;
  localparam int FRAMES = 8;
  localparam int FW     = 2;
  localparam int IO_AW  = 6;
  localparam logic [31:0] ID = 32'h2020_1641;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] fuse_word = '0;
  logic clr_bypass = 1'b0, crc_en = 1'b1;
  logic [31:0] dev_id = ID;
  logic s_valid = 1'b0;
  logic [31:0] s_data = '0;
  logic s_ready, cfg_status, frm_we, io_we, load_done, err_flag;
  logic [31:0] fuse_q, io_data;
  logic [2:0] frm_addr;
  logic [63:0] frm_data;
  logic [IO_AW-1:0] io_addr;

  int total = 0, bad = 0;
  int fcount = 0, icount = 0, early_take = 0;
  logic [63:0] fmem [FRAMES];
  logic [31:0] imem [64];
  logic [5:0]  iaddr_log [64];
  logic [31:0] bcrc;

  always #2 clk = ~clk;

  cfgl_top #(.FRAMES(FRAMES), .FRAME_WORDS(FW), .IO_AW(IO_AW)) u_cfgl_top (
    .clk(clk), .rst_n(rst_n), .fuse_word(fuse_word), .clr_bypass(clr_bypass),
    .crc_en(crc_en), .dev_id(dev_id), .s_valid(s_valid), .s_data(s_data),
    .s_ready(s_ready), .fuse_q(fuse_q), .cfg_status(cfg_status),
    .frm_we(frm_we), .frm_addr(frm_addr), .frm_data(frm_data),
    .io_we(io_we), .io_addr(io_addr), .io_data(io_data),
    .load_done(load_done), .err_flag(err_flag)
  );

  always @(negedge clk) begin
    if (frm_we) begin fmem[frm_addr] = frm_data; fcount++; end
    if (io_we) begin
      if (icount < 64) begin imem[icount] = io_data; iaddr_log[icount] = io_addr; end
      icount++;
    end
    if (!cfg_status && s_ready) early_take++;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [31:0] w);
    logic [31:0] r = c;
    for (int i = 31; i >= 0; i--) begin
      logic fb = r[31] ^ w[i];
      r = {r[30:0], 1'b0};
      if (fb) r = r ^ 32'h04C11DB7;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w);
    @(negedge clk);
    while (!s_ready) @(negedge clk);
    s_valid = 1'b1; s_data = w;
    @(negedge clk);
    s_valid = 1'b0; s_data = 32'hDEAD_BEEF;
  endtask

  task automatic send_c(input logic [31:0] w);
    bcrc = ref_crc(bcrc, w);
    send(w);
  endtask

  task automatic do_reset(input bit byp, input logic [31:0] fz);
    rst_n = 1'b0; s_valid = 1'b0; clr_bypass = byp; fuse_word = fz;
    for (int i = 0; i < FRAMES; i++) fmem[i] = 64'hFFFF_FFFF_FFFF_FFFF;
    repeat (3) @(negedge clk);
    fcount = 0; icount = 0; early_take = 0;
    rst_n = 1'b1;
    for (int i = 0; i < 100 && !cfg_status; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic head();
    send(32'h0000_0005);
    send(32'hAA55AA55);
    bcrc = 32'hFFFF_FFFF;
    send(ID);
  endtask

  task automatic finish_load(input logic [31:0] chkword_xor);
    send_c(32'h0C00_0000);
    send(bcrc ^ chkword_xor);
    @(negedge clk);
  endtask

  task automatic t_clear();
    do_reset(1'b0, 32'h1234_5678);
    chk(cfg_status == 1'b1, "R3 status released", 64'(cfg_status), 64'd1);
    chk(fcount == FRAMES, "R2 clear write count", 64'(fcount), 64'(FRAMES));
    for (int i = 0; i < FRAMES; i++)
      chk(fmem[i] == 64'd0, "R2 frame cleared to zero", fmem[i], 64'd0);
    chk(fuse_q == 32'h1234_5678, "R1 fuse captured", 64'(fuse_q), 64'h1234_5678);
    fuse_word = 32'hCAFE_0000;
    repeat (3) @(negedge clk);
    chk(fuse_q == 32'h1234_5678, "R1 fuse held", 64'(fuse_q), 64'h1234_5678);
    chk(early_take == 0, "R4 no ready before status", 64'(early_take), 64'd0);
  endtask

  task automatic t_bypass();
    do_reset(1'b1, 32'h0000_00A5);
    chk(cfg_status == 1'b1, "R3 bypass status", 64'(cfg_status), 64'd1);
    chk(fcount == 0, "R3 bypass no clear writes", 64'(fcount), 64'd0);
    chk(fuse_q == 32'hA5, "R1 fuse captured bypass", 64'(fuse_q), 64'hA5);
  endtask

  task automatic t_good();
    do_reset(1'b0, 32'h0);
    crc_en = 1'b1;
    fcount = 0;
    send(32'h0100_0003);            // R5 junk before sync, looks like an IO cmd
    head();
    send_c(32'h0000_0000);          // R7 no-op
    send_c(32'h0100_0003);
    for (int i = 1; i <= 3; i++) send_c(32'h1111_0000 + i);
    send_c(32'h7E00_0002);          // R7 unknown opcode ignored
    send_c(32'h0200_0000);          // R7 zero-count core
    send_c(32'h0200_0005);
    for (int i = 0; i < 5; i++) send_c(32'hC000_0000 + i);
    finish_load(32'h0);
    chk(icount == 3, "R8 io write count", 64'(icount), 64'd3);
    for (int i = 0; i < 3; i++) begin
      chk(imem[i] == 32'h1111_0001 + i, "R8 io data", 64'(imem[i]), 64'(32'h1111_0001 + i));
      chk(iaddr_log[i] == 6'(i), "R8 io addr", 64'(iaddr_log[i]), 64'(i));
    end
    chk(fcount == 2, "R9 frame write count", 64'(fcount), 64'd2);
    chk(fmem[0] == {32'hC000_0001, 32'hC000_0000}, "R9 frame0 packing", fmem[0], {32'hC000_0001, 32'hC000_0000});
    chk(fmem[1] == {32'hC000_0003, 32'hC000_0002}, "R9 frame1 packing", fmem[1], {32'hC000_0003, 32'hC000_0002});
    chk(fmem[2] == 64'd0, "R9 leftover dropped", fmem[2], 64'd0);
    chk(load_done == 1'b1, "R10 done after good check", 64'(load_done), 64'd1);
    chk(err_flag == 1'b0, "R10 no error", 64'(err_flag), 64'd0);
  endtask

  task automatic t_bad_id();
    do_reset(1'b1, 32'h0);
    crc_en = 1'b1;
    send(32'hAA55AA55);
    send(ID ^ 32'h1);
    send(32'h0100_0001);            // R6 must be treated as pre-sync junk
    send(32'h5555_5555);
    @(negedge clk);
    chk(err_flag == 1'b1, "R6 id mismatch error", 64'(err_flag), 64'd1);
    chk(icount == 0, "R6 no io writes after bad id", 64'(icount), 64'd0);
    chk(load_done == 1'b0, "R6 no done", 64'(load_done), 64'd0);
    head();
    send_c(32'h0200_0002);
    send_c(32'hBBBB_0000); send_c(32'hBBBB_0001);
    finish_load(32'h0);
    chk(load_done == 1'b1, "R12 reload after error", 64'(load_done), 64'd1);
    chk(fcount == 1 && fmem[0] == {32'hBBBB_0001, 32'hBBBB_0000}, "R12 reload frame", fmem[0], {32'hBBBB_0001, 32'hBBBB_0000});
    chk(err_flag == 1'b1, "R11 error sticky", 64'(err_flag), 64'd1);
  endtask

  task automatic t_bad_crc();
    do_reset(1'b1, 32'h0);
    crc_en = 1'b1;
    head();
    send_c(32'h0100_0001); send_c(32'h0000_0042);
    finish_load(32'h0000_0100);
    chk(err_flag == 1'b1, "R11 crc mismatch error", 64'(err_flag), 64'd1);
    chk(load_done == 1'b0, "R11 no done on crc fail", 64'(load_done), 64'd0);
    do_reset(1'b1, 32'h0);
    crc_en = 1'b0;
    head();
    send_c(32'h0100_0001); send_c(32'h0000_0042);
    finish_load(32'hFFFF_0000);
    chk(load_done == 1'b1, "R11 check ignored when disabled", 64'(load_done), 64'd1);
    chk(err_flag == 1'b0, "R11 no error when disabled", 64'(err_flag), 64'd0);
    crc_en = 1'b1;
  endtask

  initial begin
    chk(cfg_status == 1'b0, "R3 status low in reset", 64'(cfg_status), 64'd0);
    chk(s_ready == 1'b0, "R4 ready low in reset", 64'(s_ready), 64'd0);
    t_clear();
    t_bypass();
    t_good();
    t_bad_id();
    t_bad_crc();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule